// File: doc/BRIEF.md
# Character LCD 4-bit Start-up Sequencer

This block brings a character display controller of the common 44780-compatible kind out of an unknown state after a chip reset. It talks to the display over a write-only 4-bit bus and never reads it back. It always runs the instruction-driven wake-up sequence, so it works even when the display kept power across an FPGA reload and missed its own power-on reset.

The sequence opens with a long settling wait. Next come three 0x3 nibbles, then a 0x2 nibble that selects 4-bit transfers. Five 8-bit commands follow:

- 0x28: two lines, 5x8 font.
- 0x08: display off.
- 0x01: clear.
- 0x06: increment entry.
- 0x0F: display on with a blinking cursor.

Each command goes out as its upper nibble and then its lower nibble. One countdown timer sets the length of every phase: the data setup before the enable strobe, the strobe itself, the data hold after it, the gap between the two halves of a byte, and the wait after each item. When the last wait has run out, a done flag rises and the bus stays idle.

Every delay is a parameter counted in clock cycles. The defaults assume a 50 MHz clock: 15 ms power-up, 4.1 ms, 100 us, 40 us and 1.64 ms waits, a 12-cycle strobe and a 1 us gap between nibbles.

Top module: `lcd_init_top`

## Requirements
- R1: While reset is high, lcd_e, init_done and lcd_db (4'h0) are low. Releasing reset restarts the sequence from its first step, even if reset was applied mid-sequence.
- R2: No enable strobe is issued during the first P_PWR cycles after reset release. The first lcd_e rise is visible after rising edge P_PWR+P_SETUP+1 with reset low.
- R3: Every phase lasts exactly its programmed cycle count. The state advances only when the single countdown timer has reached zero; while it is nonzero, the timer counts down by one per cycle.
- R4: The wake-up writes are single nibbles, in this order: 0x3, 0x3, 0x3, 0x2. They are followed by waits of P_LONG, P_MID, P_SHORT and P_SHORT cycles respectively, each counted from the end of the data hold.
- R5: The commands 0x28, 0x08, 0x01, 0x06 and 0x0F follow in that order. Each is sent upper nibble first, and its two halves are separated by P_GAP idle cycles. The wait after 0x01 is P_CLEAR cycles; the wait after each other command is P_SHORT cycles.
- R6: For each nibble, lcd_db takes its value P_SETUP cycles before lcd_e rises. lcd_e then stays high for exactly P_EHIGH cycles, and lcd_db stays unchanged while lcd_e is high and for P_HOLD cycles after it falls.
- R7: lcd_rs and lcd_rw stay 0 at all times. lcd_db is always driven to a known value and keeps the last nibble sent until the next write.
- R8: init_done rises the cycle after the wait following 0x0F expires. It then stays high while lcd_e stays low and lcd_db holds 0xF.
- R9: One full sequence produces exactly 14 enable strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_rs | output | 1 | Register select, held at command (0) |
| lcd_rw | output | 1 | Read/write select, held at write (0) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db | output | 4 | Data nibble, display pins 7..4 |
| init_done | output | 1 | High once the whole sequence has finished |

## Verification
On every cycle the assertions check four things:

- The timer counts down by one when it is not reloaded.
- The state moves only on a zero count.
- The data nibble stays stable while the strobe is high, and each strobe lasts exactly P_EHIGH cycles.
- The done flag is sticky and the strobe is quiet once it is set.

The order of the nibbles, the length of each wait, the position of the first strobe, the total strobe count and the restart after a reset mid-sequence can only be shown by the bench. Its cycle-accurate reference trace, built from the requirement timings, is compared against the pins on every clock.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

    typedef enum logic [2:0] {
        PH_BOOT, PH_POWER, PH_SETUP, PH_STROBE,
        PH_HOLD, PH_GAP, PH_WAIT, PH_DONE
    } phase_t;

    typedef enum logic [1:0] {
        WAIT_LONG, WAIT_MID, WAIT_SHORT, WAIT_CLEAR
    } wait_sel_t;

    // one program item: a lone upper nibble or a full byte, then a wait
    typedef struct packed {
        logic      full_byte;
        logic [7:0] code;
        wait_sel_t  post;
    } item_t;

    localparam int ITEM_COUNT = 9;
    localparam int IDX_W      = $clog2(ITEM_COUNT + 1);

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic item_t item_at(input logic [IDX_W-1:0] idx);
        item_t it;
        case (idx)
            0:       it = '{1'b0, 8'h30, WAIT_LONG};
            1:       it = '{1'b0, 8'h30, WAIT_MID};
            2:       it = '{1'b0, 8'h30, WAIT_SHORT};
            3:       it = '{1'b0, 8'h20, WAIT_SHORT};
            4:       it = '{1'b1, 8'h28, WAIT_SHORT};
            5:       it = '{1'b1, 8'h08, WAIT_SHORT};
            6:       it = '{1'b1, 8'h01, WAIT_CLEAR};
            7:       it = '{1'b1, 8'h06, WAIT_SHORT};
            8:       it = '{1'b1, 8'h0F, WAIT_SHORT};
            default: it = '{1'b0, 8'h00, WAIT_SHORT};
        endcase
        return it;
    endfunction

endpackage

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)                count_q <= '0;
        else if (load)          count_q <= load_val;
        else if (count_q != '0) count_q <= count_q - 1'b1;
    end

    assign zero = (count_q == '0);

    // R3: an unloaded nonzero count drops by exactly one
    a_r3_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/lcd_cmd_rom.sv
module lcd_cmd_rom
    import lcd_init_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output item_t            item
);
    assign item = item_at(idx);
endmodule

// File: rtl/lcd_init_fsm.sv
module lcd_init_fsm
    import lcd_init_pkg::*;
#(
    parameter int W       = 25,
    parameter int P_PWR   = 750000,
    parameter int P_LONG  = 205000,
    parameter int P_MID   = 5000,
    parameter int P_SHORT = 2000,
    parameter int P_CLEAR = 82000,
    parameter int P_SETUP = 2,
    parameter int P_EHIGH = 12,
    parameter int P_HOLD  = 1,
    parameter int P_GAP   = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zero,
    input  item_t            item,
    output logic [IDX_W-1:0] rom_idx,
    output logic             load,
    output logic [W-1:0]     load_val,
    output logic             lcd_e,
    output logic [3:0]       lcd_db,
    output logic             done
);
    phase_t           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             low_q, low_d;
    logic [3:0]       db_q, db_d;

    function automatic logic [W-1:0] cyc(input int n);
        return W'(n - 1);
    endfunction

    function automatic logic [W-1:0] wait_len(input wait_sel_t s);
        case (s)
            WAIT_LONG:  return cyc(P_LONG);
            WAIT_MID:   return cyc(P_MID);
            WAIT_CLEAR: return cyc(P_CLEAR);
            default:    return cyc(P_SHORT);
        endcase
    endfunction

    // in the wait phase the table already points at the next item
    assign rom_idx = (phase_q == PH_WAIT) ? idx_q + 1'b1 : idx_q;

    always_comb begin
        phase_d  = phase_q;
        idx_d    = idx_q;
        low_d    = low_q;
        db_d     = db_q;
        load     = 1'b0;
        load_val = '0;
        if (zero) begin
            case (phase_q)
                PH_BOOT: begin
                    phase_d = PH_POWER; load = 1'b1; load_val = cyc(P_PWR);
                end
                PH_POWER: begin
                    phase_d = PH_SETUP; load = 1'b1; load_val = cyc(P_SETUP);
                    db_d = item.code[7:4]; low_d = 1'b0;
                end
                PH_SETUP: begin
                    phase_d = PH_STROBE; load = 1'b1; load_val = cyc(P_EHIGH);
                end
                PH_STROBE: begin
                    phase_d = PH_HOLD; load = 1'b1; load_val = cyc(P_HOLD);
                end
                PH_HOLD: begin
                    load = 1'b1;
                    if (item.full_byte && !low_q) begin
                        phase_d = PH_GAP; load_val = cyc(P_GAP);
                    end else begin
                        phase_d = PH_WAIT; load_val = wait_len(item.post);
                    end
                end
                PH_GAP: begin
                    phase_d = PH_SETUP; load = 1'b1; load_val = cyc(P_SETUP);
                    db_d = item.code[3:0]; low_d = 1'b1;
                end
                PH_WAIT: begin
                    if (idx_q == IDX_W'(ITEM_COUNT - 1)) begin
                        phase_d = PH_DONE;
                    end else begin
                        phase_d = PH_SETUP; load = 1'b1; load_val = cyc(P_SETUP);
                        idx_d = idx_q + 1'b1; db_d = item.code[7:4]; low_d = 1'b0;
                    end
                end
                default: phase_d = PH_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_BOOT;
            idx_q   <= '0;
            low_q   <= 1'b0;
            db_q    <= 4'h0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            low_q   <= low_d;
            db_q    <= db_d;
        end
    end

    assign lcd_e  = (phase_q == PH_STROBE);
    assign lcd_db = db_q;
    assign done   = (phase_q == PH_DONE);

    // strobe length tracker for the pulse-width check
    logic [W-1:0] e_run_q;
    always_ff @(posedge clk) begin
        if (rst)        e_run_q <= '0;
        else if (lcd_e) e_run_q <= e_run_q + 1'b1;
        else            e_run_q <= '0;
    end

    // R3: state moves only on a zero count from the timer
    a_r3_advance_on_zero: assert property (@(posedge clk) disable iff (rst)
        !zero |=> (phase_q == $past(phase_q)));
    // R6: data nibble steady while the strobe is high
    a_r6_db_stable_in_strobe: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> $stable(lcd_db));
    // R6: strobe width is exactly P_EHIGH cycles
    a_r6_strobe_width: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_e) |-> (e_run_q == W'(P_EHIGH)));
    // R8: done is sticky
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    // R8: bus quiet after done
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !lcd_e);

endmodule

// File: rtl/lcd_init_top.sv
module lcd_init_top
    import lcd_init_pkg::*;
#(
    parameter int P_PWR   = 750000,
    parameter int P_LONG  = 205000,
    parameter int P_MID   = 5000,
    parameter int P_SHORT = 2000,
    parameter int P_CLEAR = 82000,
    parameter int P_SETUP = 2,
    parameter int P_EHIGH = 12,
    parameter int P_HOLD  = 1,
    parameter int P_GAP   = 50
) (
    input  logic       clk,
    input  logic       rst,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [3:0] lcd_db,
    output logic       init_done
);
    localparam int MAX_A = max2(max2(P_PWR, P_LONG), max2(P_MID, P_SHORT));
    localparam int MAX_B = max2(max2(P_CLEAR, P_SETUP), max2(P_EHIGH, max2(P_HOLD, P_GAP)));
    localparam int CNT_W = $clog2(max2(MAX_A, MAX_B) + 1) + 1;

    logic             t_load, t_zero;
    logic [CNT_W-1:0] t_val;
    logic [IDX_W-1:0] r_idx;
    item_t            r_item;

    lcd_delay_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    lcd_cmd_rom u_rom (.idx(r_idx), .item(r_item));

    lcd_init_fsm #(
        .W(CNT_W), .P_PWR(P_PWR), .P_LONG(P_LONG), .P_MID(P_MID),
        .P_SHORT(P_SHORT), .P_CLEAR(P_CLEAR), .P_SETUP(P_SETUP),
        .P_EHIGH(P_EHIGH), .P_HOLD(P_HOLD), .P_GAP(P_GAP)
    ) u_fsm (
        .clk(clk), .rst(rst), .zero(t_zero), .item(r_item), .rom_idx(r_idx),
        .load(t_load), .load_val(t_val), .lcd_e(lcd_e), .lcd_db(lcd_db),
        .done(init_done)
    );

    // write-only command bus
    assign lcd_rs = 1'b0;
    assign lcd_rw = 1'b0;

endmodule

// File: tb/tb_lcd_init_top.sv
`timescale 1ns/1ps
module tb_lcd_init_top;
    localparam int P_PWR = 20, P_LONG = 9, P_MID = 5, P_SHORT = 3, P_CLEAR = 7;
    localparam int P_SETUP = 2, P_EHIGH = 4, P_HOLD = 1, P_GAP = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic lcd_rs, lcd_rw, lcd_e, init_done;
    logic [3:0] lcd_db;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lcd_init_top #(
        .P_PWR(P_PWR), .P_LONG(P_LONG), .P_MID(P_MID), .P_SHORT(P_SHORT),
        .P_CLEAR(P_CLEAR), .P_SETUP(P_SETUP), .P_EHIGH(P_EHIGH),
        .P_HOLD(P_HOLD), .P_GAP(P_GAP)
    ) dut (
        .clk(clk), .rst(rst), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
        .lcd_e(lcd_e), .lcd_db(lcd_db), .init_done(init_done)
    );

    logic       q_e[$];
    logic [3:0] q_db[$];
    logic       q_dn[$];
    string      q_tag[$];
    logic [3:0] cur;

    task automatic push_n(input int n, input logic e, input logic [3:0] d,
                          input logic dn, input string tag);
        for (int i = 0; i < n; i++) begin
            q_e.push_back(e); q_db.push_back(d); q_dn.push_back(dn); q_tag.push_back(tag);
        end
    endtask

    task automatic nibble(input logic [3:0] n, input string tag);
        push_n(P_SETUP, 1'b0, n, 1'b0, tag);   // setup before strobe (R6)
        push_n(P_EHIGH, 1'b1, n, 1'b0, "R6");
        push_n(P_HOLD, 1'b0, n, 1'b0, tag);
        cur = n;
    endtask

    task automatic build(input int extra);
        logic [3:0] wake [4] = '{4'h3, 4'h3, 4'h3, 4'h2};
        int         wwait[4] = '{P_LONG, P_MID, P_SHORT, P_SHORT};
        logic [7:0] cmd  [5] = '{8'h28, 8'h08, 8'h01, 8'h06, 8'h0F};
        int         cwait[5] = '{P_SHORT, P_SHORT, P_CLEAR, P_SHORT, P_SHORT};
        q_e.delete(); q_db.delete(); q_dn.delete(); q_tag.delete();
        cur = 4'h0;
        push_n(P_PWR, 1'b0, cur, 1'b0, "R2");
        for (int i = 0; i < 4; i++) begin
            nibble(wake[i], "R4");
            push_n(wwait[i], 1'b0, cur, 1'b0, "R3");
        end
        for (int i = 0; i < 5; i++) begin
            nibble(cmd[i][7:4], "R5");
            push_n(P_GAP, 1'b0, cur, 1'b0, "R5");
            nibble(cmd[i][3:0], "R5");
            push_n(cwait[i], 1'b0, cur, 1'b0, "R3");
        end
        push_n(extra, 1'b0, cur, 1'b1, "R8");
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_reset();
        @(negedge clk);
        check(lcd_e == 1'b0 && init_done == 1'b0 && lcd_db == 4'h0,
              "R1", "reset state {e,done,db}", {lcd_e, init_done, lcd_db}, 0);
    endtask

    // compare n cycles of the queue; returns strobe count and first-rise cycle
    task automatic run(input int n, output int rises, output int first_rise);
        logic prev_e = 1'b0;
        rises = 0; first_rise = -1;
        for (int k = 0; k < n; k++) begin
            logic e, dn; logic [3:0] d; string t;
            @(negedge clk);
            e = q_e.pop_front(); d = q_db.pop_front(); dn = q_dn.pop_front(); t = q_tag.pop_front();
            check(!$isunknown(lcd_db) && lcd_rs == 1'b0 && lcd_rw == 1'b0, "R7",
                  "rs/rw/db driven", {lcd_rs, lcd_rw, lcd_db}, {2'b00, d});
            check(lcd_e == e && lcd_db == d && init_done == dn, t,
                  $sformatf("cycle %0d {e,db,done}", k + 1),
                  {lcd_e, lcd_db, init_done}, {e, d, dn});
            if (lcd_e && !prev_e) begin
                rises++;
                if (first_rise < 0) first_rise = k + 1;
            end
            prev_e = lcd_e;
        end
    endtask

    initial begin
        int rises, first, total;
        rst = 1'b1;
        repeat (3) check_reset();
        @(negedge clk) rst = 1'b0;
        build(10);
        run(70, rises, first);                 // partial run, then reset mid-sequence
        @(negedge clk) rst = 1'b1;
        repeat (3) check_reset();              // R1: reset mid-sequence
        rst = 1'b0;
        build(25);
        total = q_e.size();
        run(total, rises, first);
        // R9: strobe count over the full sequence
        check(rises == 14, "R9", "strobe count", rises, 14);
        // R2: first strobe position after reset release
        check(first == P_PWR + P_SETUP + 1, "R2", "first strobe cycle",
              first, P_PWR + P_SETUP + 1);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule